// File: doc/BRIEF.md
# Sequential Result Register Read Pointer

This block stores the per-channel results of a multichannel converter that samples all its channels at once and converts them one after another. Each result arrives with an active-low end-of-conversion strobe. The block latches the result into the slot that matches its place in the current sequence. A host reads the results one word at a time over a shared parallel bus, using an active-low chip select and an active-low read strobe. An internal read pointer picks the slot that is driven onto the bus. A first-data flag tells the host when that pointer sits on the first slot.

Reads may overlap a conversion that is still running. A completed read moves the pointer forward only when the next slot already holds a result of the current sequence. If it does not, the move is held back and takes place when that slot's end-of-conversion strobe arrives. A read of the last selected channel sends the pointer back to the first slot. The number of selected channels comes from a configuration input.

The end-of-conversion strobe and the result come from the clock domain of the block. Chip select and the read strobe are asynchronous and pass through two-flop synchronisers. The bus enable is combinational from the raw pins.

Top module: `result_pointer_bank`

## Requirements
- R1: When the end-of-conversion input is high on one clock edge and low on the next, the result input sampled at that second edge is stored. It goes into slot 0 for the first strobe of a sequence and into the next slot for each later strobe. After the last selected slot, the next strobe starts a new sequence at slot 0.
- R2: The first end-of-conversion strobe of a sequence sets the pointer to slot 0 and cancels any held-back advance. This holds even if a read edge falls in the same cycle.
- R3: A qualified read edge moves the pointer one slot forward when the next slot holds a result of the current sequence, counting a result stored in the same cycle. Results left over from a fully completed sequence also count.
- R4: A qualified read edge whose next slot has no result yet leaves the pointer where it is. The pointer then moves one slot forward on the clock edge that stores that slot's result.
- R5: Any number of reads while a result is still missing move the pointer by at most one slot. Each of those reads returns the data at the current pointer.
- R6: A qualified read edge while the pointer is on the last selected slot (count minus one) returns the pointer to slot 0.
- R7: The first-data output is high exactly when the pointer is on slot 0.
- R8: The data bus drives the slot under the pointer while the raw chip select and read strobe are both low. In every other case it is high impedance.
- R9: The channel-count input selects 1 to 4 channels. A value of 0 acts as 1, and values above 4 act as 4.
- R10: Synchronous active-high reset clears the pointer to slot 0 and sets the first-data output high. It cancels any held-back advance, restarts the write order at slot 0 and zeroes all stored results.
- R11: A qualified read edge is a low-to-high change of the read strobe after two synchroniser flops, with the equally delayed chip select low. The pointer changes on the third rising clock edge after the raw read strobe rises. A read strobe pulse while chip select is high has no effect.
- R12: When a qualified read edge and the storing of the next slot's result fall on the same clock edge, the pointer advances by exactly one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chanCount | input | 3 | Number of selected channels (clamped to 1..4) |
| resultIn | input | 14 | Conversion result from the converter |
| eocN | input | 1 | End-of-conversion strobe, active low |
| csN | input | 1 | Chip select, active low, asynchronous |
| rdN | input | 1 | Read strobe, active low, asynchronous |
| dbOut | output | 14 | Tri-state data bus |
| firstData | output | 1 | High while the pointer is on slot 0 |

## Verification
Two functions can meet on one clock edge: the pointer advance caused by a completed read, and the storing of the result that the advance needs. The bench times a read so that its synchronised rising edge lands on the same clock edge where end-of-conversion is first seen low for the slot after the pointer. It then reads again. That read must return the freshly stored word, and the read after it must be held back, which shows the pointer moved exactly one slot. A behavioural reference model, updated every clock, also judges the first-data flag and the bus contents in every cycle of this and the other scenarios.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

  // Events passed from the datapath to the pointer control
  typedef struct packed {
    logic seqStart;         // first result of a new sequence stored this cycle
    logic nextReady;        // slot after the pointer holds a result (incl. this cycle)
    logic nextJustWritten;  // slot after the pointer is being stored this cycle
  } wrEvt_t;

endpackage

// File: rtl/rpb_datapath.sv
module rpb_datapath
  import rpb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 14,
  localparam int PTR_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  chanEff,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              eocN,
  input  logic [PTR_W-1:0]  ptr,
  output wrEvt_t            evt,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] bank [NUM_CH];
  logic [PTR_W-1:0]  wrIdx;
  logic [CNT_W-1:0]  written;
  logic              eocPrev;
  logic              eocFall;
  logic [CNT_W-1:0]  wrIdxPlus;
  logic [CNT_W-1:0]  writtenNow;
  logic [CNT_W-1:0]  ptrPlus;

  assign eocFall    = eocPrev & ~eocN;
  assign wrIdxPlus  = CNT_W'(wrIdx) + CNT_W'(1);
  assign writtenNow = eocFall ? wrIdxPlus : written;
  assign ptrPlus    = CNT_W'(ptr) + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      eocPrev <= 1'b1;
      wrIdx   <= '0;
      written <= '0;
    end else begin
      eocPrev <= eocN;
      if (eocFall) begin
        written <= wrIdxPlus;
        wrIdx   <= (wrIdxPlus >= chanEff) ? '0 : PTR_W'(wrIdxPlus);
      end
    end
  end

  // One storage slot per channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[g] <= '0;
      end else if (eocFall && (wrIdx == PTR_W'(g))) begin
        bank[g] <= resultIn;
      end
    end
  end

  always_comb begin
    evt.seqStart        = eocFall && (wrIdx == '0);
    evt.nextReady       = writtenNow > ptrPlus;
    evt.nextJustWritten = eocFall && (wrIdxPlus == ptrPlus + CNT_W'(1)) ;
  end

  assign rdData = bank[ptr];

  // R1: a falling strobe stores the sampled result in the slot in turn
  assert_store_slot_R1: assert property (@(posedge clk) disable iff (rst)
    eocFall |=> bank[$past(wrIdx)] == $past(resultIn));

  // R4: the pointer never rests on a slot with no stored result
  assert_ptr_has_data_R4: assert property (@(posedge clk) disable iff (rst)
    (ptr != '0) |-> (written > CNT_W'(ptr)));

  // R1: write order stays inside the selected channels
  assert_wr_range_R1: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(wrIdx) < chanEff);

endmodule

// File: rtl/rpb_control.sv
module rpb_control
  import rpb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int PTR_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] chanEff,
  input  logic             csN,
  input  logic             rdN,
  input  wrEvt_t           evt,
  output logic [PTR_W-1:0] ptr,
  output logic             firstData
);

  logic rdS1, rdS2, rdPrev;
  logic csS1, csS2, csPrev;
  logic rdRise;
  logic pend, pendNext;
  logic [PTR_W-1:0] ptrNext;
  logic isLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdS1 <= 1'b1; rdS2 <= 1'b1; rdPrev <= 1'b1;
      csS1 <= 1'b1; csS2 <= 1'b1; csPrev <= 1'b1;
    end else begin
      rdS1 <= rdN;  rdS2 <= rdS1; rdPrev <= rdS2;
      csS1 <= csN;  csS2 <= csS1; csPrev <= csS2;
    end
  end

  assign rdRise = rdS2 & ~rdPrev & ~csPrev;
  assign isLast = (CNT_W'(ptr) + CNT_W'(1)) >= chanEff;

  always_comb begin
    ptrNext  = ptr;
    pendNext = pend;
    if (evt.seqStart) begin
      ptrNext  = '0;
      pendNext = 1'b0;
    end else if (rdRise) begin
      if (isLast) begin
        ptrNext  = '0;
        pendNext = 1'b0;
      end else if (evt.nextReady) begin
        ptrNext  = ptr + PTR_W'(1);
        pendNext = 1'b0;
      end else begin
        pendNext = 1'b1;
      end
    end else if (pend && evt.nextJustWritten) begin
      ptrNext  = ptr + PTR_W'(1);
      pendNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      pend      <= 1'b0;
      firstData <= 1'b1;
    end else begin
      ptr       <= ptrNext;
      pend      <= pendNext;
      firstData <= (ptrNext == '0);
    end
  end

  // R6: pointer stays within the selected channels
  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(ptr) < chanEff);

  // R5: the pointer moves by one slot or returns to the first slot
  assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + PTR_W'(1) || ptr == '0));

  // R2: sequence start lands the pointer on slot 0
  assert_seq_start_R2: assert property (@(posedge clk) disable iff (rst)
    evt.seqStart |=> (ptr == '0) && firstData);

  // R7: flag matches pointer position
  assert_flag_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    firstData == (ptr == '0));

endmodule

// File: rtl/result_pointer_bank.sv
module result_pointer_bank
  import rpb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 14,
  localparam int PTR_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  chanCount,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              eocN,
  input  logic              csN,
  input  logic              rdN,
  output logic [DATA_W-1:0] dbOut,
  output logic              firstData
);

  logic [CNT_W-1:0]  chanEff;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] rdData;
  wrEvt_t            evt;

  // R9: clamp the channel count to 1..NUM_CH
  always_comb begin
    if (chanCount == '0)                   chanEff = CNT_W'(1);
    else if (chanCount > CNT_W'(NUM_CH))   chanEff = CNT_W'(NUM_CH);
    else                                   chanEff = chanCount;
  end

  rpb_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .chanEff  (chanEff),
    .resultIn (resultIn),
    .eocN     (eocN),
    .ptr      (ptr),
    .evt      (evt),
    .rdData   (rdData)
  );

  rpb_control #(.NUM_CH(NUM_CH)) i_ctl (
    .clk       (clk),
    .rst       (rst),
    .chanEff   (chanEff),
    .csN       (csN),
    .rdN       (rdN),
    .evt       (evt),
    .ptr       (ptr),
    .firstData (firstData)
  );

  // R8: bus driven only while both raw strobes are low
  assign dbOut = (!csN && !rdN) ? rdData : {DATA_W{1'bz}};

endmodule

// File: tb/test_result_pointer_bank.sv
module test_result_pointer_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  chanCount = 3'd4;
  logic [13:0] resultIn = '0;
  logic        eocN = 1'b1;
  logic        csN = 1'b0;
  logic        rdN = 1'b1;
  wire  [13:0] dbOut;
  wire         firstData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  result_pointer_bank i_result_pointer_bank (
    .clk(clk), .rst(rst), .chanCount(chanCount), .resultIn(resultIn),
    .eocN(eocN), .csN(csN), .rdN(rdN), .dbOut(dbOut), .firstData(firstData)
  );

  // Behavioural reference model
  int mPtr, mWritten, mWrIdx, mPend;
  int mBank [4];
  bit mRd [3];
  bit mCs [3];
  bit mEocPrev;

  always @(posedge clk) begin
    int n;
    bit rise, fall, start;
    int slot;
    if (rst) begin
      mPtr = 0; mWritten = 0; mWrIdx = 0; mPend = 0;
      foreach (mBank[i]) mBank[i] = 0;
      foreach (mRd[i]) begin mRd[i] = 1; mCs[i] = 1; end
      mEocPrev = 1;
    end else begin
      n = (chanCount == 0) ? 1 : (chanCount > 4) ? 4 : int'(chanCount);
      rise = mRd[1] && !mRd[2] && !mCs[2];
      fall = mEocPrev && !eocN;
      start = 0;
      slot = -1;
      if (fall) begin
        slot = mWrIdx;
        mBank[slot] = int'(resultIn);
        mWritten = slot + 1;
        start = (slot == 0);
        mWrIdx = (slot + 1 >= n) ? 0 : slot + 1;
      end
      if (start) begin
        mPtr = 0; mPend = 0;
      end else if (rise) begin
        if (mPtr == n - 1) begin mPtr = 0; mPend = 0; end
        else if (mPtr + 1 < mWritten) begin mPtr++; mPend = 0; end
        else mPend = 1;
      end else if (mPend != 0 && slot == mPtr + 1) begin
        mPtr++; mPend = 0;
      end
      mRd[2] = mRd[1]; mRd[1] = mRd[0]; mRd[0] = rdN;
      mCs[2] = mCs[1]; mCs[1] = mCs[0]; mCs[0] = csN;
      mEocPrev = eocN;
    end
  end

  // Cycle comparison, 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      checks++;
      if (firstData !== (mPtr == 0)) begin
        errors++;
        $display("FAIL R7 firstData act=%b exp=%b", firstData, mPtr == 0);
      end
      checks++;
      if (!csN && !rdN) begin
        if (dbOut !== 14'(mBank[mPtr])) begin
          errors++;
          $display("FAIL R8 bus act=%h exp=%h", dbOut, 14'(mBank[mPtr]));
        end
      end else if (dbOut !== 14'bz) begin
        errors++;
        $display("FAIL R8 bus not hi-z act=%h", dbOut);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseEoc(input logic [13:0] v);
    @(negedge clk); resultIn = v; eocN = 1'b0;
    @(negedge clk); eocN = 1'b1;
    @(negedge clk);
  endtask

  // Read one word; value sampled while strobes low, then settle
  task automatic doRead(output int v);
    @(negedge clk); rdN = 1'b0;
    @(negedge clk);
    @(negedge clk); v = int'(dbOut);
    rdN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic doReset(input logic [2:0] cnt);
    @(negedge clk); rst = 1'b1; chanCount = cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    doReset(3'd4);
    // R10: reset state
    check(firstData === 1'b1, "R10 flag after reset", int'(firstData), 1);
    check(dbOut === 14'bz, "R8 idle bus hi-z", int'(dbOut), -1);

    // R1 R3 R6: full sequence written, then read in order
    pulseEoc(14'h0101); pulseEoc(14'h0202); pulseEoc(14'h0303); pulseEoc(14'h0404);
    doRead(v); check(v == 'h0101, "R1 slot0", v, 'h0101);
    check(firstData === 1'b0, "R3 advanced", int'(firstData), 0);
    doRead(v); check(v == 'h0202, "R3 slot1", v, 'h0202);
    doRead(v); check(v == 'h0303, "R3 slot2", v, 'h0303);
    doRead(v); check(v == 'h0404, "R3 slot3", v, 'h0404);
    check(firstData === 1'b1, "R6 wrap after last", int'(firstData), 1);

    // R2 R4 R5: reads overlapping conversion
    pulseEoc(14'h1111);
    check(firstData === 1'b1, "R2 start at slot0", int'(firstData), 1);
    doRead(v); check(v == 'h1111, "R4 first read", v, 'h1111);
    check(firstData === 1'b1, "R4 held back", int'(firstData), 1);
    doRead(v); check(v == 'h1111, "R5 repeat read", v, 'h1111);
    pulseEoc(14'h2222);
    check(firstData === 1'b0, "R4 deferred advance", int'(firstData), 0);
    doRead(v); check(v == 'h2222, "R5 single step", v, 'h2222);

    // R12: read edge lands on the same clock edge as slot 2 store
    @(negedge clk); rdN = 1'b0;
    @(negedge clk); rdN = 1'b1;
    @(negedge clk);
    @(negedge clk); resultIn = 14'h3333; eocN = 1'b0;
    @(negedge clk); eocN = 1'b1;
    repeat (4) @(negedge clk);
    doRead(v); check(v == 'h3333, "R12 one step", v, 'h3333);
    doRead(v); check(v == 'h3333, "R12 next held", v, 'h3333);

    // R11: read strobes with chip select high are ignored
    csN = 1'b1;
    repeat (3) begin
      @(negedge clk); rdN = 1'b0;
      @(negedge clk); check(dbOut === 14'bz, "R11 R8 cs high hi-z", int'(dbOut), -1);
      rdN = 1'b1;
      repeat (4) @(negedge clk);
    end
    csN = 1'b0;
    pulseEoc(14'h0444);
    doRead(v); check(v == 'h0444, "R11 no advance with cs high", v, 'h0444);
    check(firstData === 1'b1, "R6 wrap", int'(firstData), 1);

    // R9: two channels
    doReset(3'd2);
    pulseEoc(14'h0aaa); pulseEoc(14'h0bbb);
    doRead(v); check(v == 'h0aaa, "R9 two ch slot0", v, 'h0aaa);
    doRead(v); check(v == 'h0bbb, "R9 two ch slot1", v, 'h0bbb);
    check(firstData === 1'b1, "R9 wrap at two", int'(firstData), 1);
    pulseEoc(14'h0ccc);
    doRead(v); check(v == 'h0ccc, "R1 new seq slot0", v, 'h0ccc);

    // R9: zero acts as one channel
    doReset(3'd0);
    pulseEoc(14'h0012);
    doRead(v); check(v == 'h0012, "R9 zero->one", v, 'h0012);
    check(firstData === 1'b1, "R9 single ch flag", int'(firstData), 1);
    pulseEoc(14'h0034);
    doRead(v); check(v == 'h0034, "R9 single ch overwrite", v, 'h0034);

    // R9: seven acts as four
    doReset(3'd7);
    pulseEoc(14'h0001); pulseEoc(14'h0002); pulseEoc(14'h0003); pulseEoc(14'h0004);
    repeat (3) doRead(v);
    check(firstData === 1'b0, "R9 clamp four not wrapped", int'(firstData), 0);
    doRead(v); check(v == 'h0004, "R9 clamp slot3", v, 'h0004);
    check(firstData === 1'b1, "R9 clamp wrap", int'(firstData), 1);

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule